// File: doc/BRIEF.md
# Coarse-Step Watchdog Timer with Reload Port

This block is a memory-mapped watchdog. A 24-bit live count runs down by one every 1024 clock cycles while the watchdog is armed. When the count is zero and the watchdog is armed, the block raises a sticky expire output. Software keeps the watchdog alive by writing to a separate reload address. Each reload refills the count from a stored 16-bit length. The length fills the upper sixteen bits of the count, and the low eight bits become zero.

Both registers sit behind a simple single-cycle bus. A write strobe, a read strobe and a 20-bit offset select the control image or the reload address. Read data is combinational. Clearing the mode field stops the watchdog: the count freezes and expiry cannot occur.

Top module: `wdog_poke_timer`

## Requirements
- R1: While the mode field is nonzero, the live count decrements exactly once per 1024 clocks. A control write or a reload write restarts the step divider, so the first decrement lands on the 1024th clock edge after that write. Modes 1, 2 and 3 all count the same way.
- R2: A write at offset 0x40000 takes effect at the next clock edge. Data bits 1:0 become the mode, bits 19:4 become the length, and bits 43:20 become the live count. The same write clears the expire output.
- R3: A read at offset 0x40000 returns, in the same cycle, the mode in bits 1:0, the length in bits 19:4 and the live count in bits 43:20, with every other bit zero. A read at any other offset returns zero.
- R4: A write of any data at offset 0x50000 loads the live count with the length shifted left by eight (low eight bits zero). This happens in every mode.
- R5: With mode 0, the live count holds its value and the expire output stays low.
- R6: When the live count is zero and the mode is nonzero, expire goes high one cycle later. It stays high through reloads until the next control write or reset.
- R7: Length 0xFFFF reloads the count to 0xFFFF00, the longest timeout. The count never wraps below zero.
- R8: An active-low synchronous reset clears the mode, length, live count, step divider and expire output.
- R9: A reload that falls on the same clock as a step decrement wins: the count takes the reload value, with no decrement applied.
- R10: Writes to offsets other than 0x40000 and 0x50000 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 20 | Byte offset within the block window |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, combinational |
| expire | output | 1 | Sticky timeout flag |

## Verification
A reload write and the step divider's terminal cycle can land on the same edge. That edge could either decrement the count or refill it. The bench arms the counter and waits exactly 1023 edges. It then presents the reload on the 1024th edge. It expects the pure reload value, with no decrement. It then expects the next decrement a full 1024 edges later, which shows the divider restarted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_M1   = 2'd1,
        WD_M2   = 2'd2,
        WD_RUN  = 2'd3
    } wd_mode_e;

    localparam int unsigned WD_ADDR_W    = 20;
    localparam logic [WD_ADDR_W-1:0] WD_CTRL_OFS = 20'h40000;
    localparam logic [WD_ADDR_W-1:0] WD_POKE_OFS = 20'h50000;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode #(
    parameter int unsigned ADDR_W = 20,
    parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
    parameter logic [ADDR_W-1:0] POKE_OFS = '1
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              ctrl_wr,
    output logic              poke_wr,
    output logic              ctrl_rd
);
    logic hit_ctrl;
    logic hit_poke;

    always_comb begin
        hit_ctrl = (addr == CTRL_OFS);
        hit_poke = (addr == POKE_OFS);
        ctrl_wr  = wr_en && hit_ctrl;
        poke_wr  = wr_en && hit_poke;
        ctrl_rd  = rd_en && hit_ctrl;
    end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned PRESC_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic en,
    output logic tick
);
    logic [PRESC_W-1:0] div_d, div_q;

    always_comb begin
        tick = en && !restart && (div_q == {PRESC_W{1'b1}});
        if (restart || !en) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/wdog_poke_timer.sv
module wdog_poke_timer
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W  = WD_ADDR_W,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned PRESC_W = 10,
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned PAD_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = WD_CTRL_OFS,
    parameter logic [ADDR_W-1:0] POKE_OFS = WD_POKE_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              expire
);
    localparam int unsigned CNT_W   = LEN_W + PAD_W;
    localparam int unsigned MODE_W  = 2;
    localparam int unsigned MODE_LSB = 0;
    localparam int unsigned LEN_LSB = 4;
    localparam int unsigned CNT_LSB = LEN_LSB + LEN_W;

    typedef struct packed {
        wd_mode_e         mode;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic             expire;
    } wd_state_t;

    wd_state_t d, q;

    logic ctrl_wr, poke_wr, ctrl_rd;
    logic tick;
    logic armed;

    logic [MODE_W-1:0] mode_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  cnt_q;

    wdog_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .POKE_OFS (POKE_OFS)
    ) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .ctrl_wr (ctrl_wr),
        .poke_wr (poke_wr),
        .ctrl_rd (ctrl_rd)
    );

    assign armed = (q.mode != WD_OFF);

    wdog_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr || poke_wr),
        .en      (armed),
        .tick    (tick)
    );

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            d.mode   = wd_mode_e'(wdata[MODE_LSB +: MODE_W]);
            d.len    = wdata[LEN_LSB +: LEN_W];
            d.cnt    = wdata[CNT_LSB +: CNT_W];
            d.expire = 1'b0;
        end else begin
            if (poke_wr) begin
                d.cnt = {q.len, {PAD_W{1'b0}}};
            end else if (armed && tick && (q.cnt != '0)) begin
                d.cnt = q.cnt - 1'b1;
            end
            if (armed && (q.cnt == '0)) begin
                d.expire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{mode: WD_OFF, len: '0, cnt: '0, expire: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        if (ctrl_rd) begin
            rdata[MODE_LSB +: MODE_W] = q.mode;
            rdata[LEN_LSB +: LEN_W]   = q.len;
            rdata[CNT_LSB +: CNT_W]   = q.cnt;
        end
    end

    assign expire = q.expire;
    assign mode_q = q.mode;
    assign len_q  = q.len;
    assign cnt_q  = q.cnt;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             poke_wr,
    input logic             tick,
    input logic [1:0]       mode_q,
    input logic [LEN_W-1:0] len_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             expire
);
    localparam int unsigned PAD_W = CNT_W - LEN_W;

    AST_STOP_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0) |-> !expire); // R5

    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0 && !ctrl_wr && !poke_wr) |=> $stable(cnt_q)); // R5

    AST_POKE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (poke_wr && !ctrl_wr) |=> (cnt_q == {$past(len_q), {PAD_W{1'b0}}})); // R4

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !poke_wr && !tick) |=> $stable(cnt_q)); // R1

    AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr && !poke_wr && mode_q != 2'd0 && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !ctrl_wr && !poke_wr) |=> (cnt_q == '0)); // R7

    AST_EXPIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl_wr) |=> expire); // R6

    AST_EXPIRE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'd0 && cnt_q == '0 && !ctrl_wr) |=> expire); // R6
endmodule

bind wdog_poke_timer wdog_chk #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .poke_wr (poke_wr),
    .tick    (tick),
    .mode_q  (mode_q),
    .len_q   (len_q),
    .cnt_q   (cnt_q),
    .expire  (expire)
);

// File: tb/sim_wdog_poke_timer.sv
`timescale 1ns/1ps
module sim_wdog_poke_timer;
    localparam logic [19:0] CTRL = 20'h40000;
    localparam logic [19:0] POKE = 20'h50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [19:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        expire;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdog_poke_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .expire(expire)
    );

    function automatic logic [63:0] img(input logic [1:0] m, input logic [15:0] l,
                                        input logic [23:0] c);
        return {20'h0, c, l, 2'b00, m};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [63:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1);
        rd(CTRL, v);
        chk("R8 ctrl after reset", v, 64'h0);
        chk("R8 expire after reset", {63'h0, expire}, 64'h0);
        wr(CTRL, img(2'd3, 16'h0042, 24'h000300));
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(CTRL, v);
        chk("R8 ctrl after mid-run reset", v, 64'h0);
    endtask

    task automatic t_fields();
        logic [63:0] v;
        wr(CTRL, 64'hFFFF_F000_0000_0000 | img(2'd2, 16'h1234, 24'hABCDEF) | 64'h0C);
        rd(CTRL, v);
        chk("R2/R3 field image", v, img(2'd2, 16'h1234, 24'hABCDEF));
        rd(POKE, v);
        chk("R3 read of reload offset", v, 64'h0);
        rd(20'h40008, v);
        chk("R3 read of unmapped offset", v, 64'h0);
    endtask

    task automatic t_prescale();
        logic [63:0] v;
        wr(CTRL, img(2'd1, 16'h0003, 24'h000005));
        idle(1023);
        rd(CTRL, v);
        chk("R1 count held through 1023 edges", v, img(2'd1, 16'h0003, 24'h000005));
        idle(1);
        rd(CTRL, v);
        chk("R1 decrement at edge 1024", v, img(2'd1, 16'h0003, 24'h000004));
        idle(1024);
        rd(CTRL, v);
        chk("R1 second decrement", v, img(2'd1, 16'h0003, 24'h000003));
    endtask

    task automatic t_collide();
        logic [63:0] v;
        wr(CTRL, img(2'd3, 16'h0002, 24'h000005));
        idle(1022);
        @(negedge clk);
        wr_en = 1'b1; addr = POKE; wdata = 64'h0;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
        rd(CTRL, v);
        chk("R9 reload wins over step", v, img(2'd3, 16'h0002, 24'h000200));
        idle(1023);
        rd(CTRL, v);
        chk("R1 divider restarted by reload", v, img(2'd3, 16'h0002, 24'h000200));
        idle(1);
        rd(CTRL, v);
        chk("R1 first step after reload", v, img(2'd3, 16'h0002, 24'h0001FF));
    endtask

    task automatic t_stop();
        logic [63:0] v;
        wr(CTRL, img(2'd0, 16'h0002, 24'h000003));
        idle(3000);
        rd(CTRL, v);
        chk("R5 stopped count frozen", v, img(2'd0, 16'h0002, 24'h000003));
        wr(POKE, 64'h5A5A);
        idle(1100);
        rd(CTRL, v);
        chk("R4 reload while stopped", v, img(2'd0, 16'h0002, 24'h000200));
        wr(CTRL, 64'h0);
        idle(10);
        chk("R5 no expire with zero count and mode 0", {63'h0, expire}, 64'h0);
    endtask

    task automatic t_expire();
        logic [63:0] v;
        wr(CTRL, img(2'd3, 16'h0001, 24'h000001));
        idle(1024);
        rd(CTRL, v);
        chk("R1 count reached zero", v, img(2'd3, 16'h0001, 24'h000000));
        chk("R6 expire not yet", {63'h0, expire}, 64'h0);
        idle(1);
        chk("R6 expire one cycle after zero", {63'h0, expire}, 64'h1);
        idle(1100);
        rd(CTRL, v);
        chk("R7 count does not wrap", v, img(2'd3, 16'h0001, 24'h000000));
        wr(POKE, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(CTRL, v);
        chk("R4 reload value", v, img(2'd3, 16'h0001, 24'h000100));
        chk("R6 expire sticky across reload", {63'h0, expire}, 64'h1);
        wr(CTRL, img(2'd0, 16'h0001, 24'h000007));
        chk("R2 control write clears expire", {63'h0, expire}, 64'h0);
    endtask

    task automatic t_sat();
        logic [63:0] v;
        wr(CTRL, img(2'd3, 16'hFFFF, 24'h000800));
        wr(POKE, 64'h1);
        rd(CTRL, v);
        chk("R7 longest reload", v, img(2'd3, 16'hFFFF, 24'hFFFF00));
    endtask

    task automatic t_ignore();
        logic [63:0] v;
        wr(CTRL, img(2'd3, 16'h0005, 24'h000040));
        wr(20'h40008, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(20'h50010, 64'h0);
        rd(CTRL, v);
        chk("R10 unmapped writes ignored", v, img(2'd3, 16'h0005, 24'h000040));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fields();
        t_prescale();
        t_collide();
        t_stop();
        t_expire();
        t_sat();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule